// File: doc/BRIEF.md
# Target-Time Periodic Clock Output

This block produces a square-wave or single-edge output whose edges are placed at absolute instants of a free-running system time. A 64-bit target time is compared every cycle with the incoming system time. When the time has reached the target and the output is armed, the pin level flips, an interrupt pulse may be raised, and in periodic mode the target moves forward by a 64-bit period. Nothing here counts cycles: every edge follows from the time comparison alone.

Software first writes zero to the control word to stop the output. It then sets the pin to output drive with the timing function selected, and loads the first target and the period as low and high 32-bit words. The period is given in the same scaled units as the system time, so a one-second half-period is the nanosecond count shifted left by the time counter's scale shift. Writing the control word with the enable bit set starts the output. Working out a start time that falls on a second boundary is left to software.

Top module: `timed_pulse_out`

## Requirements
- R1: After reset `pinOut`, `pinDir` and `irqPulse` are all 0.
- R2: `pinDir` equals bit 0 (drive enable) of the last value written to the pin configuration word (address 1). Bit 1 of that word selects the timing function.
- R3: The pin never toggles unless the control enable bit (address 0, bit 0), pin drive (address 1, bit 0) and timing function (address 1, bit 1) are all set.
- R4: While armed, the pin toggles at the first clock edge at which the sampled `sysTime` is greater than or equal to the target. The comparison is unsigned over all 64 bits.
- R5: In periodic mode (control bit 1 set), every toggle adds the period to the target, with wrap modulo 2^64. With time stepping by 1 per cycle from 0, a target T and a period P give one toggle at each time T+kP.
- R6: In single-shot mode (control bit 1 clear), only one toggle happens. Later toggles need a fresh write to the control word, and the target is left unchanged.
- R7: `irqPulse` is high for the cycle after each toggle edge when control bit 2 (interrupt enable) is set. It stays low when that bit is clear.
- R8: A control write with the enable bit clear drives `pinOut` low from the write edge onwards. No toggle and no interrupt occur on that edge.
- R9: A target that is already in the past when the output is enabled fires at the first edge after the enabling write.
- R10: Address 2 and address 3 load the low and high words of the target. Address 4 and address 5 load the low and high words of the period. A software load takes priority over the hardware advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 control, 1 pin config, 2/3 target lo/hi, 4/5 period lo/hi) |
| wrData | input | 32 | Register write data |
| sysTime | input | 64 | System time, scaled units |
| pinOut | output | 1 | Clock output level |
| pinDir | output | 1 | Pin drive enable |
| irqPulse | output | 1 | One-cycle event pulse |

## Verification
The assertions check on every cycle that a toggle only happens when the comparator reports the target as reached and the pin is driven. They also check that a target advance never happens without a toggle, that a toggle and a forced-low never coincide, that single-shot mode cannot fire twice in a row, and that an interrupt only follows an interrupt-enabled state. The bench scenarios are the only place where the timing comes out. They show the exact count and placement of edges when the target and period are swept, the full 64-bit carry of the comparison, catch-up firing on a past target, and single-shot re-arming.

// File: rtl/timed_pulse_pkg.sv
package timed_pulse_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PIN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TGTLO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TGTHI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PERLO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PERHI = 3'd5;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PER  = 1;
  localparam int CTRL_INT  = 2;
  localparam int PIN_DRIVE = 0;
  localparam int PIN_FUNC  = 1;

  typedef struct packed {
    logic loadTgtLo;
    logic loadTgtHi;
    logic loadPerLo;
    logic loadPerHi;
    logic advance;
    logic togglePin;
    logic clearPin;
  } strobeT;
endpackage

// File: rtl/timed_pulse_ctrl.sv
module timed_pulse_ctrl
  import timed_pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        cfgData,
  input  logic              reached,
  output strobeT            strb,
  output logic              pinDir,
  output logic              irqPulse
);
  logic enBit, perBit, intBit, driveBit, funcBit, spent, irqQ;
  logic ctrlWr, pinWr, disableWr, armed, fire;

  assign ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);
  assign pinWr     = wrEn && (wrAddr == ADDR_PIN);
  assign disableWr = ctrlWr && !cfgData[CTRL_EN];
  assign armed     = enBit && driveBit && funcBit && !spent;
  assign fire      = armed && reached && !disableWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit <= 1'b0; perBit <= 1'b0; intBit <= 1'b0;
      driveBit <= 1'b0; funcBit <= 1'b0; spent <= 1'b0; irqQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enBit  <= cfgData[CTRL_EN];
        perBit <= cfgData[CTRL_PER];
        intBit <= cfgData[CTRL_INT];
        spent  <= 1'b0;
      end else if (fire && !perBit) begin
        spent <= 1'b1;
      end
      if (pinWr) begin
        driveBit <= cfgData[PIN_DRIVE];
        funcBit  <= cfgData[PIN_FUNC];
      end
      irqQ <= fire && intBit;
    end
  end

  always_comb begin
    strb = '0;
    strb.loadTgtLo = wrEn && (wrAddr == ADDR_TGTLO);
    strb.loadTgtHi = wrEn && (wrAddr == ADDR_TGTHI);
    strb.loadPerLo = wrEn && (wrAddr == ADDR_PERLO);
    strb.loadPerHi = wrEn && (wrAddr == ADDR_PERHI);
    strb.togglePin = fire;
    strb.advance   = fire && perBit;
    strb.clearPin  = !enBit || disableWr;
  end

  assign pinDir   = driveBit;
  assign irqPulse = irqQ;

  // R6: single-shot mode never fires on two consecutive edges without a re-arm
  assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !perBit && !ctrlWr) |=> !fire);
  // R7: an interrupt only follows a cycle with interrupts enabled
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(intBit));
endmodule

// File: rtl/timed_pulse_path.sv
module timed_pulse_path
  import timed_pulse_pkg::*;
#(
  parameter int WORD_W = REG_W,
  parameter int WORDS  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strb,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W*WORDS-1:0]  sysTime,
  output logic                     reached,
  output logic                     pinLevel
);
  localparam int TIME_W = WORD_W * WORDS;

  logic [TIME_W-1:0] target, period, advSum;
  logic              clkState;

  assign advSum  = target + period;
  assign reached = (sysTime >= target);

  for (genvar h = 0; h < WORDS; h++) begin : gWord
    logic ldTgt, ldPer;
    assign ldTgt = (h == 0) ? strb.loadTgtLo : strb.loadTgtHi;
    assign ldPer = (h == 0) ? strb.loadPerLo : strb.loadPerHi;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        target[h*WORD_W +: WORD_W] <= '0;
        period[h*WORD_W +: WORD_W] <= '0;
      end else begin
        if (ldTgt)             target[h*WORD_W +: WORD_W] <= wrData;
        else if (strb.advance) target[h*WORD_W +: WORD_W] <= advSum[h*WORD_W +: WORD_W];
        if (ldPer)             period[h*WORD_W +: WORD_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               clkState <= 1'b0;
    else if (strb.clearPin)  clkState <= 1'b0;
    else if (strb.togglePin) clkState <= !clkState;
  end

  assign pinLevel = clkState;

  // R4: a toggle request only arrives while the comparator reports the target reached
  assert_toggle_reached_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.togglePin |-> reached);
  // R5: the target only advances together with a toggle
  assert_advance_toggle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> strb.togglePin);
  // R8: a forced-low and a toggle never coincide
  assert_clear_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clearPin && strb.togglePin));
endmodule

// File: rtl/timed_pulse_out.sv
module timed_pulse_out
  import timed_pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [63:0]       sysTime,
  output logic              pinOut,
  output logic              pinDir,
  output logic              irqPulse
);
  strobeT strb;
  logic   reached;

  timed_pulse_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgData(wrData[2:0]), .reached(reached), .strb(strb),
    .pinDir(pinDir), .irqPulse(irqPulse)
  );

  timed_pulse_path #(.WORD_W(REG_W), .WORDS(2)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .sysTime(sysTime), .reached(reached), .pinLevel(pinOut)
  );

  // R3: the pin only toggles while it is driven
  assert_toggle_driven_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.togglePin |-> pinDir);
endmodule

// File: tb/timed_pulse_out_test.sv
module timed_pulse_out_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [63:0] sysTime = '0;
  logic        pinOut, pinDir, irqPulse;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  timed_pulse_out uut (.*);

  always #10 clk = !clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setup(input logic [31:0] pinCfg, input logic [63:0] tgt, input logic [63:0] per);
    wr(3'd0, 32'd0);
    wr(3'd1, pinCfg);
    wr(3'd2, tgt[31:0]); wr(3'd3, tgt[63:32]);
    wr(3'd4, per[31:0]); wr(3'd5, per[63:32]);
  endtask

  task automatic ramp(input logic [63:0] base, input int n, output int tog, output int irqs);
    logic prev;
    prev = pinOut; tog = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      sysTime = base + 64'(i);
      @(posedge clk); @(negedge clk);
      if (pinOut != prev) tog++;
      prev = pinOut;
      if (irqPulse) irqs++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tog, irqs, expT;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pinOut == 0 && pinDir == 0 && irqPulse == 0, "R1 reset", {pinOut, pinDir, irqPulse}, 0);

    // R4 R5 R7: sweep target and period, time stepping 1 per cycle over 30 values
    for (int t = 0; t < 6; t++) begin
      for (int p = 1; p < 7; p++) begin
        setup(32'h3, 64'(t), 64'(p));
        sysTime = 0;
        wr(3'd0, 32'h7);
        ramp(64'd0, 30, tog, irqs);
        expT = (29 - t) / p + 1;
        check(tog == expT, "R5 toggle count", tog, expT);
        check(irqs == expT, "R7 irq count", irqs, expT);
        check(pinOut == 1'(expT % 2), "R4 final level", pinOut, expT % 2);
      end
    end

    // R2 R3: pin drive without timing function, then function without drive
    setup(32'h1, 64'd2, 64'd3);
    sysTime = 0; wr(3'd0, 32'h7);
    check(pinDir == 1, "R2 drive bit", pinDir, 1);
    ramp(64'd0, 20, tog, irqs);
    check(tog == 0 && irqs == 0, "R3 no function", tog + irqs, 0);
    setup(32'h2, 64'd2, 64'd3);
    sysTime = 0; wr(3'd0, 32'h7);
    check(pinDir == 0, "R2 no drive", pinDir, 0);
    ramp(64'd0, 20, tog, irqs);
    check(tog == 0 && irqs == 0, "R3 no drive", tog + irqs, 0);

    // R7 interrupts disabled
    setup(32'h3, 64'd1, 64'd4);
    sysTime = 0; wr(3'd0, 32'h3);
    ramp(64'd0, 20, tog, irqs);
    check(tog == 5, "R7 toggles without irq", tog, 5);
    check(irqs == 0, "R7 irq masked", irqs, 0);

    // R6 single-shot, then re-arm with time already past the unchanged target (R9)
    setup(32'h3, 64'd3, 64'd2);
    sysTime = 0; wr(3'd0, 32'h5);
    ramp(64'd0, 20, tog, irqs);
    check(tog == 1 && irqs == 1, "R6 single shot", tog, 1);
    sysTime = 64'd19; wr(3'd0, 32'h5);
    @(posedge clk); @(negedge clk);
    check(pinOut == 0 && irqPulse == 1, "R6 re-arm fires", {pinOut, irqPulse}, 1);
    ramp(64'd19, 5, tog, irqs);
    check(tog == 0, "R6 stays spent", tog, 0);

    // R9 past target fires on first edge; R8 disable forces low
    setup(32'h3, 64'd5, 64'd1000);
    sysTime = 64'd100; wr(3'd0, 32'h7);
    @(posedge clk); @(negedge clk);
    check(pinOut == 1 && irqPulse == 1, "R9 past target", {pinOut, irqPulse}, 3);
    ramp(64'd100, 4, tog, irqs);
    check(tog == 0, "R9 single catch-up", tog, 0);
    sysTime = 64'd2000;
    wr(3'd0, 32'h0);
    check(pinOut == 0 && irqPulse == 0, "R8 disable low", {pinOut, irqPulse}, 0);
    ramp(64'd3000, 3, tog, irqs);
    check(tog == 0 && irqs == 0, "R8 stays off", tog + irqs, 0);

    // R4 R10: carry into the high word
    setup(32'h3, 64'h1_0000_0000, 64'd1);
    sysTime = 64'h0_FFFF_FFF0; wr(3'd0, 32'h3);
    ramp(64'h0_FFFF_FFF0, 15, tog, irqs);
    check(tog == 0, "R4 high word below", tog, 0);
    ramp(64'h1_0000_0000, 1, tog, irqs);
    check(tog == 1, "R10 high word reached", tog, 1);

    // R10: load in the same cycle as a hardware advance wins
    setup(32'h3, 64'd0, 64'd1);
    sysTime = 64'd50; wr(3'd0, 32'h3);
    wr(3'd2, 32'd500);
    ramp(64'd60, 3, tog, irqs);
    check(tog == 0, "R10 load priority", tog, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule